// File: doc/BRIEF.md
# Packed Word Multiply-Accumulate Unit

This block multiplies two 64-bit operands lane by lane. Each operand holds four signed 16-bit words, and the four lane products are formed in parallel. A 2-bit function code selects one of three ways to shape the 64-bit result:

- keep the low 16 bits of each lane product in that lane;
- keep the high 16 bits of each lane product in that lane;
- add the products of neighbouring lanes into two 32-bit sums.

The pairwise-sum function is the building block for dot products and FIR filters. An eight-element dot product takes two operations on two operand pairs, and software then adds the four partial sums.

The unit is a two-stage pipeline. The first stage registers the full signed products. The second stage registers the selected or summed result. It accepts a new operation on every clock edge where the input strobe is high. The output strobe marks each result exactly two cycles after its operation was taken.

Top module: `pmac_unit`

## Requirements
- R1: Each lane product is the full signed two's-complement product of the two 16-bit lane values. For example, 0xFFFF times 0x0001 gives 0xFFFFFFFF, and 0x8000 times 0x8000 gives 0x40000000.
- R2: Function code 2'b00 (low) puts bits 15:0 of the product of lane i into result bits 16i+15:16i, for i = 0 to 3.
- R3: Function code 2'b01 (high) puts bits 31:16 of the product of lane i into result bits 16i+15:16i.
- R4: Function code 2'b10 (pair sum) puts lane0 product + lane1 product into result bits 31:0, and lane2 product + lane3 product into result bits 63:32.
- R5: In pair-sum mode the 32-bit sum wraps and does not saturate. When all four lane values of a pair are 0x8000, that half of the result is 0x80000000.
- R6: Function code 2'b11 is reserved and produces an all-zero result.
- R7: The output strobe rises for exactly one result, two clock edges after the edge that took the operation, and never without an operation.
- R8: Operations issued on consecutive cycles each produce their own result on consecutive cycles, in issue order.
- R9: The result output keeps its value in every cycle in which no result is delivered.
- R10: While reset is held low, and right after it is released, the output strobe is 0 and the result is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe; operands and function are taken on this edge |
| fn | input | 2 | Function: 00 low half, 01 high half, 10 pair sum, 11 reserved |
| opa | input | 64 | First operand, four signed 16-bit lanes |
| opb | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| result | output | 64 | Shaped result |

## Verification
The assertions check these properties on every cycle:

- the sign of each non-zero lane product;
- the low pair sum against the registered products;
- the zero result for the reserved code;
- the hold of the result when no operation completes;
- the two-cycle strobe latency.

Some properties only the bench scenarios can show:

- the exact values of the low, high and summed fields for the most negative and most positive lane values;
- the wrap of the all-0x8000 pair sum;
- the ordering of back-to-back bursts against a reference model.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
   typedef enum logic [1:0] {
      PM_LO   = 2'b00,
      PM_HI   = 2'b01,
      PM_PAIR = 2'b10,
      PM_NONE = 2'b11
   } pm_fn_e;
endpackage

// File: rtl/pmac_lane_mul.sv
// One signed lane multiplier, product registered (pipeline stage one).
module pmac_lane_mul #(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      b,
   output logic [2*W-1:0]    prod
);
   localparam int PW = 2 * W;

   logic signed [PW-1:0] prod_d;

   always_comb prod_d = $signed(a) * $signed(b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prod <= '0;
      else if (en) prod <= prod_d;
   end

   // R1
   prod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && a != '0 && b != '0) |=> prod[PW-1] == $past(a[W-1] ^ b[W-1]));
endmodule

// File: rtl/pmac_combine.sv
// Stage two: lane-half selection or pairwise summation, registered.
module pmac_combine
   import pmac_pkg::*;
#(
   parameter int W     = 16,
   parameter int LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  pm_fn_e                  fn,
   input  logic [LANES*2*W-1:0]    prods,
   output logic                    out_valid,
   output logic [LANES*W-1:0]      res
);
   localparam int PW    = 2 * W;
   localparam int OW    = LANES * W;
   localparam int PAIRS = LANES / 2;

   logic [OW-1:0] lo_sel, hi_sel, pair_sum, res_d;

   for (genvar i = 0; i < LANES; i++) begin : g_half
      assign lo_sel[i*W +: W] = prods[i*PW +: W];
      assign hi_sel[i*W +: W] = prods[i*PW + W +: W];
   end

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign pair_sum[p*PW +: PW] = prods[(2*p)*PW +: PW] + prods[(2*p+1)*PW +: PW];
   end

   always_comb begin
      unique case (fn)
         PM_LO:   res_d = lo_sel;
         PM_HI:   res_d = hi_sel;
         PM_PAIR: res_d = pair_sum;
         default: res_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res       <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) res <= res_d;
      end
   end

   // R4
   pair_low_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fn == PM_PAIR) |=>
         res[PW-1:0] == $past(prods[PW-1:0] + prods[2*PW-1:PW]));

   // R6
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fn == PM_NONE) |=> res == '0);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res));
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
   import pmac_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              fn,
   input  logic [LANES*LANE_W-1:0] opa,
   input  logic [LANES*LANE_W-1:0] opb,
   output logic                    out_valid,
   output logic [LANES*LANE_W-1:0] result
);
   localparam int PW = 2 * LANE_W;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("pmac_unit: LANES must be even and at least 2");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("pmac_unit: LANE_W must be at least 2");
   end

   logic               s1_valid;
   pm_fn_e             s1_fn;
   logic [LANES*PW-1:0] s1_prods;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_fn    <= PM_LO;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) s1_fn <= pm_fn_e'(fn);
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pmac_lane_mul #(.W(LANE_W)) u_mul (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (in_valid),
         .a    (opa[i*LANE_W +: LANE_W]),
         .b    (opb[i*LANE_W +: LANE_W]),
         .prod (s1_prods[i*PW +: PW])
      );
   end

   pmac_combine #(.W(LANE_W), .LANES(LANES)) u_comb (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s1_valid),
      .fn       (s1_fn),
      .prods    (s1_prods),
      .out_valid(out_valid),
      .res      (result)
   );

   // cycles since reset, saturating, so the latency check never looks before reset
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R7
   latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n || since_rst < 2'd2)
      out_valid == $past(in_valid, 2));

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd0) |-> (!out_valid && result == '0));
endmodule

// File: tb/pmac_unit_bench.sv
module pmac_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  fn = 2'b00;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [63:0] result;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   logic [63:0] exp_q[$];
   string       tag_q[$];
   int          cyc_q[$];
   logic [63:0] last_res = '0;
   bit          have_last = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pmac_unit u_pmac_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fn(fn),
      .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] f);
      logic signed [31:0] p [4];
      logic [63:0] r;
      for (int i = 0; i < 4; i++)
         p[i] = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
      r = '0;
      case (f)
         2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
         2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
         2'b10: begin
            r[31:0]  = p[0] + p[1];
            r[63:32] = p[2] + p[3];
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic issue(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] f, input string tag);
      @(negedge clk);
      opa = a; opb = b; fn = f; in_valid = 1'b1;
      exp_q.push_back(model(a, b, f));
      tag_q.push_back(tag);
      cyc_q.push_back(cyc + 2);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         opa = 64'hDEAD_BEEF_0BAD_F00D; opb = ~opa; fn = 2'b10;
      end
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && cyc > 0) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 spurious strobe", result, 64'h0);
            end else begin
               logic [63:0] e;
               string t;
               int c;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               c = cyc_q.pop_front();
               check(result === e, t, result, e);
               check(c == cyc, "R7 latency", 64'(cyc), 64'(c));
            end
            last_res = result;
            have_last = 1'b1;
         end else if (have_last) begin
            check(result === last_res, "R9 hold", result, last_res);
         end
      end
   end

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] corner [5];
      corner[0] = 16'h8000; corner[1] = 16'h7FFF; corner[2] = 16'hFFFF;
      corner[3] = 16'h0000; corner[4] = 16'h0001;

      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R10 reset strobe", {63'h0, out_valid}, 64'h0);
      check(result === 64'h0, "R10 reset result", result, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0 && result === 64'h0, "R10 after release", result, 64'h0);

      // R1 R2 R3 signed products with known values
      issue(64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0001_FFFE, 2'b00, "R2 low");
      idle(1);
      issue(64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0001_FFFE, 2'b01, "R3 high");
      idle(2);
      // R1 direct values: lane0 -1*1 high=FFFF, lane1 -32768*-32768 high=4000
      issue(64'h0000_0000_8000_FFFF, 64'h0000_0000_8000_0001, 2'b01, "R1 signed");
      idle(3);
      // R4 pair sum
      issue(64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, 2'b10, "R4 pair");
      // R5 wrap case in both halves
      issue(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b10, "R5 wrap");
      // R6 reserved code
      issue(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'b11, "R6 reserved");
      idle(4);

      // R8 back-to-back burst over corner values, all functions
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++)
            issue({corner[i], corner[j], corner[(i+j)%5], corner[(i+1)%5]},
                  {corner[j], corner[i], corner[(i+2)%5], corner[(j+3)%5]},
                  2'((i + j) % 4), "R8 burst");
      idle(3);

      // random mix with gaps
      for (int n = 0; n < 300; n++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         issue(a, b, 2'($urandom % 4), "R4 random");
         if (($urandom % 4) == 0) idle(1 + $urandom % 3);
      end
      idle(6);

      check(exp_q.size() == 0, "R7 drained", 64'(exp_q.size()), 64'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule